// File: doc/BRIEF.md
# Trace Power-Down Status Register

This block is a single read-only status word for a trace unit, placed on a simple APB-style debug bus. It tells a debugger three things. Bit 5 gives the current OS Lock level of the processor. Bit 1 is a sticky flag: it warns that trace register contents may have been lost because the trace core power domain went down. Bit 0 reports that the register was reachable, so it reads as one on every successful read.

The sticky flag comes up set after reset. It is set again whenever the core domain reports that it is unpowered. A successful read returns the flag's current value and then clears the flag, one cycle after the access phase. While the core domain is off, any access to the register ends with a bus error and changes nothing. Writes to the register while the domain is powered complete without error and are ignored.

Top module: `trace_pwr_status`

## Requirements
- R1: The read word is 32 bits wide, with bit 5 = OS Lock, bit 1 = sticky power-down and bit 0 = power status. Bits 31:6 and 4:2 always read as zero.
- R2: On a successful read, bit 5 equals `os_lock` (1 = locked). The OS Lock level does not affect whether the access is allowed.
- R3: After a synchronous reset (`rst_n` low at a clock edge), the first successful read returns bit 1 = 1.
- R4: In any cycle where `core_pwr_on` is 0, the sticky bit is set to 1, and the next successful read returns bit 1 = 1.
- R5: A successful read returns the sticky bit's current value. It clears the bit at the end of the cycle that follows the access phase, so a later read returns bit 1 = 0 unless power was lost in between.
- R6: Bit 0 reads as 1 on every successful read of the register.
- R7: An access (read or write) to the register while `core_pwr_on` is 0 raises `pslverr` in the access phase, returns `prdata` = 0 and does not clear the sticky bit.
- R8: The register decodes at byte offset 0x314. Address bits 1:0 are ignored. Any other word address returns `prdata` = 0 with no error and no side effect.
- R9: A write to the register while powered completes with `pslverr` = 0, returns `prdata` = 0 and changes no state.
- R10: If the core domain is unpowered in the cycle that follows a clearing read's access phase, the set wins and the sticky bit stays 1.
- R11: `pready` is always 1, so every access completes in one access-phase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| core_pwr_on | input | 1 | Trace core power domain is powered |
| os_lock | input | 1 | OS Lock level, 1 = locked |
| prdata | output | 32 | Read data, zero outside a successful read |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Error response in the access phase |

## Verification
Two things can happen in the same cycle: the deferred clear from a read, which lands the cycle after its access phase, and a power-loss set. The bench provokes this by dropping `core_pwr_on` for exactly the cycle after a read's access phase, then restoring power and reading again. It judges the outcome by whether that second read returns bit 1 = 1, which shows the set won. A control sequence without the power drop must read bit 1 = 0.

// File: rtl/trpd_pkg.sv
// Package: field positions and per-access decode flags shared by the
// trace power-down status logic. Assumes a 32-bit register word.
package trpd_pkg;
    localparam int REG_W      = 32;
    localparam int OSLK_BIT   = 5;
    localparam int STICKY_BIT = 1;
    localparam int PWR_BIT    = 0;

    // Classification of the current bus cycle against this register.
    typedef struct packed {
        logic rd_ok;   // successful read in the access phase
        logic err;     // access to the register while unpowered
    } trpd_acc_t;
endpackage

// File: rtl/trpd_decode.sv
// Module: trpd_decode
// Classifies the current bus cycle. A hit needs the access phase (psel and
// penable) and a word address equal to REG_OFS; byte-lane bits are ignored.
// Assumes the bus never holds penable without psel.
module trpd_decode
    import trpd_pkg::*;
#(
    parameter int              ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 12'h314
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              core_pwr_on,
    output trpd_acc_t         acc_o
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    logic hit;

    // Address match on the word, qualified by the access phase.
    always_comb begin
        hit          = psel && penable && (((paddr ^ REG_OFS) & WORD_MASK) == '0);
        acc_o.err    = hit && !core_pwr_on;
        acc_o.rd_ok  = hit && core_pwr_on && !pwrite;
    end

    // R7: an erroring access can never count as a successful read.
    always_comb begin
        a_r7_err_excludes_read: assert (!(acc_o.err && acc_o.rd_ok));
    end
endmodule

// File: rtl/trpd_sticky.sv
// Module: trpd_sticky
// Holds the sticky power-down flag. Reset sets it, an unpowered core domain
// sets it, and a successful read clears it one cycle after the access phase.
// When set and clear meet in one cycle, the set wins.
module trpd_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic core_pwr_on,
    input  logic rd_ok,
    output logic sticky_o
);
    logic clr_q;

    // Delay the read-clear request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= rd_ok;
    end

    // Update the flag: reset or power loss sets it, a pending clear clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)            sticky_o <= 1'b1;
        else if (!core_pwr_on) sticky_o <= 1'b1;
        else if (clr_q)        sticky_o <= 1'b0;
    end

    // R3: the flag is set right after reset is released.
    a_r3_reset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sticky_o);
    // R4: an unpowered cycle leaves the flag set.
    a_r4_power_loss_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_on |=> sticky_o);
    // R5: a read followed by a powered cycle clears the flag.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok ##1 core_pwr_on |=> !sticky_o);
    // R10: power loss in the clear cycle keeps the flag set.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok ##1 !core_pwr_on |=> sticky_o);
endmodule

// File: rtl/trpd_rdata.sv
// Module: trpd_rdata
// Forms the 32-bit read word from the field sources and drives zero unless
// the current cycle is a successful read.
module trpd_rdata
    import trpd_pkg::*;
(
    input  logic             rd_ok,
    input  logic             sticky,
    input  logic             os_lock,
    output logic [REG_W-1:0] prdata_o
);
    logic [REG_W-1:0] word;

    // Place each field at its bit; every other bit is zero.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i == OSLK_BIT) begin : g_lock
            assign word[i] = os_lock;
        end else if (i == STICKY_BIT) begin : g_sticky
            assign word[i] = sticky;
        end else if (i == PWR_BIT) begin : g_pwr
            assign word[i] = 1'b1;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end

    // Gate the word onto the bus only for a successful read.
    always_comb begin
        prdata_o = rd_ok ? word : '0;
    end
endmodule

// File: rtl/trace_pwr_status.sv
// Module: trace_pwr_status
// Read-only trace power-down status register on an APB-style bus. It reports
// the OS Lock, the sticky power-down flag and power status. Accesses error
// while the core domain is off. Assumes zero-wait-state transfers.
module trace_pwr_status
    import trpd_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] REG_OFS = 12'h314
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic              core_pwr_on,
    input  logic              os_lock,
    output logic [REG_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    trpd_acc_t acc;
    logic      sticky;

    trpd_decode #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_decode (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .core_pwr_on(core_pwr_on), .acc_o(acc)
    );

    trpd_sticky u_sticky (
        .clk(clk), .rst_n(rst_n), .core_pwr_on(core_pwr_on),
        .rd_ok(acc.rd_ok), .sticky_o(sticky)
    );

    trpd_rdata u_rdata (
        .rd_ok(acc.rd_ok), .sticky(sticky), .os_lock(os_lock), .prdata_o(prdata)
    );

    // Zero-wait transfers; the error flag comes straight from the decode.
    always_comb begin
        pready  = 1'b1;
        pslverr = acc.err;
    end

    logic reg_hit_acc;
    always_comb reg_hit_acc = psel && penable && (((paddr ^ REG_OFS) & WORD_MASK) == '0);

    // R1: reserved bits never read as one.
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> (prdata[31:6] == '0 && prdata[4:2] == '0));
    // R2: the lock bit follows the lock input on a good read.
    a_r2_lock_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit_acc && !pwrite && core_pwr_on) |-> (prdata[5] == os_lock));
    // R6: the power bit is one on a good read.
    a_r6_power_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit_acc && !pwrite && !pslverr) |-> prdata[0]);
    // R7: an unpowered access returns no data.
    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (prdata == '0));
    // R9: a powered write never errors.
    a_r9_write_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && core_pwr_on) |-> !pslverr);
endmodule

// File: tb/trace_pwr_status_bench.sv
`timescale 1ns/1ps
module trace_pwr_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic        core_pwr_on = 1'b1, os_lock = 1'b0;
    logic [31:0] prdata;
    logic        pready, pslverr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    trace_pwr_status u_trace_pwr_status (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .core_pwr_on(core_pwr_on), .os_lock(os_lock),
        .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    // Entry: {pwr, lock, write, addr[11:0], exp_err, exp_data[31:0]}; run in order.
    localparam int NV = 11;
    localparam logic [47:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 1'b0, 12'h314, 1'b0, 32'h0000_0003}, // R3 R5 R6: first read after reset
        {1'b1, 1'b0, 1'b0, 12'h314, 1'b0, 32'h0000_0001}, // R5: cleared by previous read
        {1'b1, 1'b1, 1'b0, 12'h314, 1'b0, 32'h0000_0021}, // R2: locked
        {1'b1, 1'b1, 1'b1, 12'h314, 1'b0, 32'h0000_0000}, // R9: write ignored
        {1'b1, 1'b0, 1'b0, 12'h310, 1'b0, 32'h0000_0000}, // R8: other offset
        {1'b0, 1'b0, 1'b0, 12'h314, 1'b1, 32'h0000_0000}, // R7: unpowered read
        {1'b0, 1'b1, 1'b1, 12'h314, 1'b1, 32'h0000_0000}, // R7: unpowered write
        {1'b1, 1'b1, 1'b0, 12'h314, 1'b0, 32'h0000_0023}, // R4: set by power loss
        {1'b1, 1'b0, 1'b0, 12'h314, 1'b0, 32'h0000_0001}, // R5: cleared again
        {1'b1, 1'b0, 1'b0, 12'h318, 1'b0, 32'h0000_0000}, // R8: next word
        {1'b1, 1'b1, 1'b0, 12'h317, 1'b0, 32'h0000_0021}  // R1 R8: byte lane ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer: setup phase, access phase (sampled mid-cycle), then idle.
    task automatic xfer(input logic pwr, input logic lock, input logic wr,
                        input logic [11:0] addr, output logic [31:0] rd, output logic err);
        @(negedge clk);
        core_pwr_on = pwr; os_lock = lock;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr;
        chk("R11 pready", {31'b0, pready}, 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; core_pwr_on = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R11 pready in reset", {31'b0, pready}, 32'h1);
        chk("R7 pslverr idle in reset", {31'b0, pslverr}, 32'h0);
        chk("R1 prdata idle in reset", prdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
            summary();
        end
    end

    initial begin
        logic [31:0] rd;
        logic        err;

        do_reset();

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][47], VEC[i][46], VEC[i][45], VEC[i][44:33], rd, err);
            chk($sformatf("vec %0d pslverr", i), {31'b0, err}, {31'b0, VEC[i][32]});
            chk($sformatf("vec %0d prdata", i), rd, VEC[i][31:0]);
        end

        // R3: reset with the flag clear brings it back to one.
        do_reset();
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R3 sticky after reset", rd, 32'h3);

        // R9: a powered write does not clear the flag.
        do_reset();
        xfer(1'b1, 1'b0, 1'b1, 12'h314, rd, err);
        chk("R9 write err", {31'b0, err}, 32'h0);
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R9 flag kept after write", rd, 32'h3);

        // R8: reads elsewhere do not clear the flag.
        do_reset();
        xfer(1'b1, 1'b0, 1'b0, 12'h000, rd, err);
        chk("R8 other offset data", rd, 32'h0);
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R8 flag kept after other read", rd, 32'h3);

        // R10: power drops exactly in the cycle the clear lands.
        do_reset();
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R10 first read", rd, 32'h3);
        core_pwr_on = 1'b0;
        @(negedge clk);
        core_pwr_on = 1'b1;
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R10 set wins over clear", rd, 32'h3);

        // R4: a one-cycle power glitch with no access sets the flag.
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R5 cleared before glitch", rd, 32'h1);
        @(negedge clk);
        core_pwr_on = 1'b0;
        @(negedge clk);
        core_pwr_on = 1'b1;
        xfer(1'b1, 1'b0, 1'b0, 12'h314, rd, err);
        chk("R4 glitch sets flag", rd, 32'h3);

        summary();
    end
endmodule